// File: doc/BRIEF.md
# Look-Ahead One-Tap Decision Feedback Equalizer

This block turns a stream of signed, digitized channel samples (one per symbol) into binary decisions while cancelling the interference left by the symbol just before. The first post-cursor weight `h1` is programmable. Each decision is used to cancel that interference from the next sample. Pre-cursor interference cannot be removed from past decisions, so a feed-forward stage ahead of this block has to handle it.

A direct implementation would subtract the feedback and then slice within one symbol time. This block does not. It builds both possible equalized values for every sample at the same time: one assumes the previous symbol was +1 (sample minus `h1`) and one assumes it was -1 (sample plus `h1`). It slices each of them and registers both results. One register then holds the previous decision and steers a two-way multiplexer that picks the surviving branch. That register and multiplexer form the only loop left. Next to each decision the block gives the sign of the slicer error, meaning the equalized value minus the ideal level of the chosen symbol, for use by an adaptation loop.

Both sides of the block are valid/ready streams. An item moves from input to output in two stages. Every stage advances together whenever the output register is empty or the consumer takes its contents. While the output holds data that the consumer does not take, the pipeline freezes and `in_ready` is low. Wrong decisions feed back just like correct ones. The block has no recovery mechanism for this.

Top module: `lookahead_dfe`

## Requirements
- R1: After reset, `out_valid` is 0 and the stored previous decision is logic 0 (symbol -1). The first sample after reset is therefore judged as sample plus `h1`.
- R2: A decision is logic 1 (symbol +1) when the selected equalized value is greater than or equal to zero. Otherwise it is logic 0. An equalized value of exactly zero decides 1.
- R3: If the previous decision is 1, the selected equalized value is sample minus `h1`. If the previous decision is 0, it is sample plus `h1`.
- R4: Each decision that enters the output register becomes the previous decision for the next sample accepted after it.
- R5: `out_err_neg` is 1 when the equalized value is strictly below the ideal level of the decided symbol, and 0 otherwise. The ideal level is +REF_LEVEL for a 1 and -REF_LEVEL for a 0. A value equal to the ideal level gives 0.
- R6: With `out_ready` held high, a sample accepted at a clock edge shows `out_valid` high after the second following edge (two-cycle latency), and not after the first.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_err_neg` hold their values and `out_valid` stays 1.
- R8: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1, and 0 otherwise.
- R9: Cycles with no accepted input leave the previous decision unchanged, so a gap in the stream does not change how the next sample is judged.
- R10: A wrong decision still feeds back into the next sample unchanged, with no recovery. Decisions after an error follow the same rule as any others.
- R11: The `h1` value used for a sample is the one present when that sample is accepted. Changing `h1` later does not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | SAMPLE_W | Signed digitized channel sample |
| h1_weight | input | TAP_W | Signed first post-cursor weight |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_bit | output | 1 | Decision, 1 = symbol +1, 0 = symbol -1 |
| out_err_neg | output | 1 | 1 when the equalized value is below the decided ideal level |

## Verification
The checker watches the stream contract on every cycle. Outputs stay frozen under back-pressure, `in_ready` follows the output register state, no output appears before a matching acceptance two cycles earlier, and the pipeline is empty straight after reset. The numeric behaviour can only be shown by the bench scenarios, which compare against a reference model kept in the bench. These cover which branch is chosen, the zero and ideal-level boundaries, the reset hypothesis, holding the previous decision across stream gaps, using `h1` as it was at acceptance, and error propagation after a flipped decision.

// File: rtl/lad_pkg.sv
package lad_pkg;
  // Result of one speculative slicer branch.
  typedef struct packed {
    logic dec;      // 1 = symbol +1
    logic err_neg;  // equalized value below ideal level of dec
  } lad_branch_t;
endpackage

// File: rtl/lad_branch.sv
module lad_branch
  import lad_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int TAP_W     = 8,
  parameter int REF_LEVEL = 32,
  parameter bit HYP_PLUS  = 1'b1  // assumed previous symbol: 1 = +1, 0 = -1
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [TAP_W-1:0]    h1,
  output lad_branch_t                res
);
  localparam int MAXW = (SAMPLE_W > TAP_W) ? SAMPLE_W : TAP_W;
  localparam int EQW  = MAXW + 2;
  localparam int ERW  = EQW + 1;
  localparam logic signed [ERW-1:0] LVL_POS = ERW'(REF_LEVEL);
  localparam logic signed [ERW-1:0] LVL_NEG = -ERW'(REF_LEVEL);

  logic signed [EQW-1:0] s_ext, h_ext, eq;
  logic signed [ERW-1:0] eq_ext, diff;

  always_comb begin
    s_ext = EQW'(sample);
    h_ext = EQW'(h1);
    // Cancel the post-cursor implied by the hypothesis
    if (HYP_PLUS) eq = s_ext - h_ext;
    else          eq = s_ext + h_ext;
    res.dec = ~eq[EQW-1];
    eq_ext  = ERW'(eq);
    diff    = eq_ext - (res.dec ? LVL_POS : LVL_NEG);
    res.err_neg = diff[ERW-1];
  end
endmodule

// File: rtl/lad_select.sv
module lad_select
  import lad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  input  logic        take,
  input  lad_branch_t br_plus,
  input  lad_branch_t br_minus,
  output lad_branch_t pick
);
  logic prev_q;

  // The single remaining feedback loop: prev_q -> mux -> prev_q
  assign pick = prev_q ? br_plus : br_minus;

  always_ff @(posedge clk) begin
    if (!rst_n)                 prev_q <= 1'b0;
    else if (advance && take)   prev_q <= pick.dec;
  end
endmodule

// File: rtl/lookahead_dfe.sv
module lookahead_dfe
  import lad_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int TAP_W     = 8,
  parameter int REF_LEVEL = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [TAP_W-1:0]    h1_weight,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit,
  output logic                out_err_neg
);
  localparam int NBR = 2;  // one branch per hypothesis of the previous symbol

  logic        advance;
  lad_branch_t br_now [NBR];
  lad_branch_t br_q   [NBR];
  logic        s1_valid;
  lad_branch_t chosen;

  assign advance  = ~out_valid | out_ready;
  assign in_ready = advance;

  // Speculative slicers: index 0 assumes +1, index 1 assumes -1
  for (genvar g = 0; g < NBR; g++) begin : g_branch
    lad_branch #(
      .SAMPLE_W (SAMPLE_W),
      .TAP_W    (TAP_W),
      .REF_LEVEL(REF_LEVEL),
      .HYP_PLUS (g == 0)
    ) u_branch (
      .sample(in_sample),
      .h1    (h1_weight),
      .res   (br_now[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)       br_q[g] <= '0;
      else if (advance) br_q[g] <= br_now[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       s1_valid <= 1'b0;
    else if (advance) s1_valid <= in_valid;
  end

  lad_select u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .take    (s1_valid),
    .br_plus (br_q[0]),
    .br_minus(br_q[1]),
    .pick    (chosen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bit     <= 1'b0;
      out_err_neg <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_bit     <= chosen.dec;
        out_err_neg <= chosen.err_neg;
      end
    end
  end
endmodule

// File: rtl/lad_checker.sv
module lad_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_err_neg
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2'd0 |-> !out_valid);

  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_err_neg)));

  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_ready, 2) && $past(in_ready, 1)) |-> out_valid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid && !$past(out_valid)) |-> $past(in_valid && in_ready, 2));
endmodule

bind lookahead_dfe lad_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bit    (out_bit),
  .out_err_neg(out_err_neg)
);

// File: tb/lookahead_dfe_tb.sv
module lookahead_dfe_tb;
  localparam int SW = 8, TW = 8, REF = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [SW-1:0] in_sample = '0;
  logic [TW-1:0] h1_weight = '0;
  logic in_ready, out_valid, out_bit, out_err_neg;

  int checks = 0, failures = 0;
  int model_prev = 0;
  bit exp_bit[$], exp_err[$], got_bit[$], got_err[$];

  always #5 clk = ~clk;

  lookahead_dfe #(.SAMPLE_W(SW), .TAP_W(TW), .REF_LEVEL(REF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .h1_weight(h1_weight), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .out_err_neg(out_err_neg));

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      got_bit.push_back(out_bit);
      got_err.push_back(out_err_neg);
    end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_prev = 0;
    exp_bit.delete(); exp_err.delete(); got_bit.delete(); got_err.delete();
  endtask

  // Model of the requirements (R2, R3, R4, R5)
  task automatic model(int x, int h);
    int y, d;
    y = model_prev ? x - h : x + h;
    d = (y >= 0) ? 1 : 0;
    exp_bit.push_back(d[0]);
    exp_err.push_back((y - (d ? REF : -REF)) < 0);
    model_prev = d;
  endtask

  // Drive one sample at a falling edge and wait until it is taken
  task automatic push(int x, int h);
    in_sample = SW'(x); h1_weight = TW'(h); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model(x, h);
  endtask

  task automatic drain(string req);
    int n;
    n = 0;
    while (got_bit.size() < exp_bit.size() && n < 50) begin
      @(negedge clk); n++;
    end
    check({req, " count"}, got_bit.size(), exp_bit.size());
    for (int i = 0; i < exp_bit.size() && i < got_bit.size(); i++) begin
      check({req, " bit"}, got_bit[i], exp_bit[i]);
      check({req, " err"}, got_err[i], exp_err[i]);
    end
    exp_bit.delete(); exp_err.delete(); got_bit.delete(); got_err.delete();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out_valid after reset", out_valid, 0);
    check("R8 in_ready when empty", in_ready, 1);
  endtask

  task automatic t_first_hyp();
    do_reset();
    push(-5, 10);            // prev=0 -> -5+10=5 -> 1
    drain("R1 first sample hypothesis");
    check("R1 direct bit", exp_bit.size(), 0);
  endtask

  task automatic t_boundaries();
    do_reset();
    push(-10, 10);           // y=0 -> decide 1 (R2), 0-32<0 -> err 1
    push(42, 10);            // prev=1, y=32 equals ideal -> err 0 (R5)
    push(-42, 10);           // prev=1, y=-52 -> 0, -52+32<0 -> err 1
    push(-22, 10);           // prev=0, y=-12 -> 0, err 0
    drain("R2 R5 boundaries");
  endtask

  task automatic t_latency();
    do_reset();
    in_sample = SW'(50); h1_weight = TW'(5); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; model(50, 5);
    check("R6 not valid after one edge", out_valid, 0);
    @(negedge clk);
    check("R6 valid after two edges", out_valid, 1);
    drain("R6 latency");
  endtask

  task automatic t_stream();
    do_reset();
    for (int i = 0; i < 24; i++) push(((i * 37) % 120) - 60, 20);
    drain("R3 R4 stream h1=20");
    for (int i = 0; i < 16; i++) push(((i * 53) % 200) - 100, -15);
    drain("R3 R4 stream negative h1");
  endtask

  task automatic t_backpressure();
    bit b0, e0;
    do_reset();
    out_ready = 1'b0;
    in_sample = SW'(30); h1_weight = TW'(8); in_valid = 1'b1;
    @(negedge clk); model(30, 8);
    in_sample = SW'(-70);
    @(negedge clk); model(-70, 8);
    in_sample = SW'(40);
    check("R7 out_valid while stalled", out_valid, 1);
    check("R8 in_ready low while stalled", in_ready, 0);
    b0 = out_bit; e0 = out_err_neg;
    repeat (4) @(negedge clk);
    check("R7 bit held", out_bit, b0);
    check("R7 err held", out_err_neg, e0);
    check("R7 still valid", out_valid, 1);
    out_ready = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk); model(40, 8);
    in_valid = 1'b0;
    drain("R7 back-pressure order");
  endtask

  task automatic t_idle();
    do_reset();
    push(60, 25);            // decide 1
    repeat (6) @(negedge clk);
    push(10, 25);            // prev must still be 1: 10-25 -> 0
    repeat (3) @(negedge clk);
    push(10, 25);            // prev 0: 35 -> 1
    drain("R9 idle gaps");
  endtask

  task automatic t_errprop();
    do_reset();
    push(40, 30);            // 1
    push(-5, 30);            // prev 1: -35 -> 0 (noise flip)
    push(20, 30);            // prev 0: 50 -> 1
    push(-25, 30);           // prev 1: -55 -> 0
    push(-40, 30);           // prev 0: -10 -> 0
    drain("R10 error propagation");
  endtask

  task automatic t_h1_timing();
    do_reset();
    push(5, 40);             // 45 -> 1
    push(20, 40);            // prev 1: -20 -> 0
    push(20, -40);           // prev 0: -20 -> 0
    push(-30, -40);          // prev 0: -70 -> 0
    in_sample = SW'(10); h1_weight = TW'(15); in_valid = 1'b1;
    @(negedge clk); model(10, 15);
    in_valid = 1'b0; h1_weight = TW'(-100);  // late change, no effect
    drain("R11 h1 at acceptance");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_first_hyp();
    t_boundaries();
    t_latency();
    t_stream();
    t_backpressure();
    t_idle();
    t_errprop();
    t_h1_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule